// File: doc/BRIEF.md
# DDR SDRAM Command Spacing Monitor

This block is a passive observer placed beside a DDR SDRAM controller's command path. Each clock it takes one decoded command, which may be a no-operation, and a 2-bit bank number. It never drives the memory. It keeps saturating elapsed-cycle counters for each bank and for the whole device, and compares every new command with the minimum spacing that the memory needs. When a command arrives too early, or a row stays open longer than allowed, it raises a one-cycle violation pulse together with a code vector that has one bit per rule.

Spacings given in nanoseconds are parameters. They are turned into clock counts at elaboration by rounding up against the clock period parameter. Spacings that are defined in clocks are parameters in clocks. The monitor follows the commands as they actually happened: a command that breaks a rule still opens, closes or restarts the state it touches.

Top module: `ddr_tmon_top`

## Requirements
Command encoding on `cmd_op`: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge one bank, 5 precharge all banks, 6 refresh, 7 mode-register set. Elapsed cycles between two commands means the difference of their clock indices.
- R1: A read (2) or write (3) to a bank fewer than ceil(TRCD_NS/period) cycles after that bank's activate (1) sets code bit 0.
- R2: An activate (1) to a bank fewer than ceil(TRP_NS/period) cycles after a precharge (4 or 5) closed that bank sets code bit 1.
- R3: A precharge (4 or 5) that closes an open bank fewer than ceil(TRAS_NS/period) cycles after its activate sets code bit 2.
- R4: A bank still open exactly ceil(TRAS_MAX_NS/period) cycles after its activate, and not precharged in that cycle, sets code bit 3 once. Further idle cycles report nothing, and a precharge in that very cycle is legal.
- R5: An activate (1) to a bank fewer than ceil(TRC_NS/period) cycles after the previous activate of the same bank sets code bit 4.
- R6: An activate (1) fewer than ceil(TRRD_NS/period) cycles after the last activate sets code bit 5 only when the two banks differ.
- R7: A precharge (4 or 5) that closes a bank fewer than BURST_CLK+TWR_CLK cycles after a write (3) to that bank sets code bit 6.
- R8: A read or write (2, 3) to any bank fewer than TCCD_CLK cycles after the previous read or write sets code bit 7.
- R9: Any command other than no-op (0) fewer than TMRD_CLK cycles after a mode-register set (7) sets code bit 8.
- R10: An activate (1) fewer than ceil(TRFC_NS/period) cycles after a refresh (6) sets code bit 9.
- R11: Precharge-all (5) checks bits 2 and 6 for every open bank, closes them all, and restarts the bit-1 timing of each bank it closed.
- R12: A precharge (4) to a bank that is not open is ignored. It reports no bit 2 or 6 and does not restart that bank's bit-1 timing.
- R13: The code is registered and appears in the cycle after the offending command. It holds for one cycle. The pulse is high exactly when some code bit is set, and several bits may be set together.
- R14: During reset the code and pulse are zero. After reset, and after any idle period however long, every counter reads as fully elapsed, so no command is flagged for spacing from before reset or from long ago.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one command is sampled per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Decoded command, encoded as listed above |
| cmd_bank | input | BANK_W (2) | Target bank for activate, read, write and single precharge |
| viol_pulse | output | 1 | High for one cycle when any rule fails |
| viol_code | output | 10 | One bit per rule, bit positions as in R1 to R10 |

## Verification
A wrong counter or a wrong open flag shows at the ports on the cycle right after the next command to that bank. That command either gets a code bit it should not have, or lacks one it should have. So every directed case probes the exact boundary cycle, one cycle short and on the limit, to expose off-by-one errors in counter restart or saturation. A wrong open or overdue flag can stay hidden until a precharge or the row-open deadline. For that reason the long-open case runs past the deadline and then far past the counter width, to show that the timeout fires exactly once and never wraps into a second report.

// File: rtl/ddr_tmon_pkg.sv
package ddr_tmon_pkg;
  timeunit 1ns;
  timeprecision 100ps;

  typedef enum logic [2:0] {
    OP_NOP  = 3'd0,
    OP_ACT  = 3'd1,
    OP_RD   = 3'd2,
    OP_WR   = 3'd3,
    OP_PRE  = 3'd4,
    OP_PREA = 3'd5,
    OP_REF  = 3'd6,
    OP_MRS  = 3'd7
  } op_e;

  // Rule positions inside the violation code
  localparam int NRULE    = 10;
  localparam int R_RCD    = 0;
  localparam int R_RP     = 1;
  localparam int R_RASMIN = 2;
  localparam int R_RASMAX = 3;
  localparam int R_RC     = 4;
  localparam int R_RRD    = 5;
  localparam int R_WTP    = 6;
  localparam int R_CCD    = 7;
  localparam int R_MRD    = 8;
  localparam int R_RFC    = 9;

  // Nanoseconds to clocks, rounded up
  function automatic int ns_to_clk(input int ns, input int clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Bits needed to hold values 0..lim
  function automatic int cnt_width(input int lim);
    return $clog2(lim + 1);
  endfunction
endpackage

// File: rtl/ddr_tmon_elapsed.sv
// Saturating elapsed-cycle counter: reads 1 in the cycle after a restart,
// k cycles later reads k, and stops at LIMIT. Resets to LIMIT.
module ddr_tmon_elapsed #(
  parameter int LIMIT = 1,
  parameter int W     = ddr_tmon_pkg::cnt_width(LIMIT)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] elapsed
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam logic [W-1:0] TOP = W'(LIMIT);
  localparam logic [W-1:0] ONE = W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               elapsed <= TOP;
    else if (restart)         elapsed <= ONE;
    else if (elapsed != TOP)  elapsed <= elapsed + ONE;
  end
endmodule

// File: rtl/ddr_tmon_bank.sv
// Per-bank rules: activate-to-column, precharge-to-activate, row active
// minimum and maximum, row cycle, write-to-precharge.
module ddr_tmon_bank
  import ddr_tmon_pkg::*;
#(
  parameter int RCD    = 3,
  parameter int RP     = 3,
  parameter int RAS    = 6,
  parameter int RASMAX = 16000,
  parameter int RC     = 9,
  parameter int WTP    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic act_hit,
  input  logic col_hit,
  input  logic wr_hit,
  input  logic pre_hit,
  output logic v_rcd,
  output logic v_rp,
  output logic v_rasmin,
  output logic v_rasmax,
  output logic v_rc,
  output logic v_wtp
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int ACT_LIM = at_least_one(max_of(max_of(RCD, RAS), max_of(RC, RASMAX)));
  localparam int PRE_LIM = at_least_one(RP);
  localparam int WR_LIM  = at_least_one(WTP);
  localparam int ACT_W   = cnt_width(ACT_LIM);
  localparam int PRE_W   = cnt_width(PRE_LIM);
  localparam int WR_W    = cnt_width(WR_LIM);

  localparam logic [ACT_W-1:0] RCD_V    = ACT_W'(RCD);
  localparam logic [ACT_W-1:0] RAS_V    = ACT_W'(RAS);
  localparam logic [ACT_W-1:0] RASMAX_V = ACT_W'(RASMAX);
  localparam logic [ACT_W-1:0] RC_V     = ACT_W'(RC);
  localparam logic [PRE_W-1:0] RP_V     = PRE_W'(RP);
  localparam logic [WR_W-1:0]  WTP_V    = WR_W'(WTP);

  logic [ACT_W-1:0] act_el;
  logic [PRE_W-1:0] pre_el;
  logic [WR_W-1:0]  wr_el;
  logic             open_q;
  logic             overdue_q;
  logic             closing;

  // A precharge only has effect on an open row
  assign closing = pre_hit && open_q;

  ddr_tmon_elapsed #(.LIMIT(ACT_LIM)) u_act_el (
    .clk(clk), .rst_n(rst_n), .restart(act_hit), .elapsed(act_el));
  ddr_tmon_elapsed #(.LIMIT(PRE_LIM)) u_pre_el (
    .clk(clk), .rst_n(rst_n), .restart(closing), .elapsed(pre_el));
  ddr_tmon_elapsed #(.LIMIT(WR_LIM)) u_wr_el (
    .clk(clk), .rst_n(rst_n), .restart(wr_hit), .elapsed(wr_el));

  always_comb begin
    v_rcd    = col_hit && (act_el < RCD_V);
    v_rc     = act_hit && (act_el < RC_V);
    v_rp     = act_hit && (pre_el < RP_V);
    v_rasmin = closing && (act_el < RAS_V);
    v_wtp    = closing && (wr_el < WTP_V);
    v_rasmax = open_q && !overdue_q && !closing && (act_el == RASMAX_V);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q    <= 1'b0;
      overdue_q <= 1'b0;
    end else begin
      if (act_hit)      open_q <= 1'b1;
      else if (closing) open_q <= 1'b0;
      if (act_hit || closing) overdue_q <= 1'b0;
      else if (v_rasmax)      overdue_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ddr_tmon_global.sv
// Device-wide rules: activate-to-activate across banks, column spacing,
// mode-register delay, refresh-to-activate.
module ddr_tmon_global
  import ddr_tmon_pkg::*;
#(
  parameter int BANK_W = 2,
  parameter int RRD    = 2,
  parameter int CCD    = 1,
  parameter int MRD    = 2,
  parameter int RFC    = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_any,
  input  logic              col_any,
  input  logic              mrs_any,
  input  logic              ref_any,
  input  logic              busy_any,
  input  logic [BANK_W-1:0] bank,
  output logic              v_rrd,
  output logic              v_ccd,
  output logic              v_mrd,
  output logic              v_rfc
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int RRD_LIM = at_least_one(RRD);
  localparam int CCD_LIM = at_least_one(CCD);
  localparam int MRD_LIM = at_least_one(MRD);
  localparam int RFC_LIM = at_least_one(RFC);
  localparam int RRD_W   = cnt_width(RRD_LIM);
  localparam int CCD_W   = cnt_width(CCD_LIM);
  localparam int MRD_W   = cnt_width(MRD_LIM);
  localparam int RFC_W   = cnt_width(RFC_LIM);

  logic [RRD_W-1:0]  rrd_el;
  logic [CCD_W-1:0]  ccd_el;
  logic [MRD_W-1:0]  mrd_el;
  logic [RFC_W-1:0]  rfc_el;
  logic [BANK_W-1:0] last_act_bank;

  ddr_tmon_elapsed #(.LIMIT(RRD_LIM)) u_rrd_el (
    .clk(clk), .rst_n(rst_n), .restart(act_any), .elapsed(rrd_el));
  ddr_tmon_elapsed #(.LIMIT(CCD_LIM)) u_ccd_el (
    .clk(clk), .rst_n(rst_n), .restart(col_any), .elapsed(ccd_el));
  ddr_tmon_elapsed #(.LIMIT(MRD_LIM)) u_mrd_el (
    .clk(clk), .rst_n(rst_n), .restart(mrs_any), .elapsed(mrd_el));
  ddr_tmon_elapsed #(.LIMIT(RFC_LIM)) u_rfc_el (
    .clk(clk), .rst_n(rst_n), .restart(ref_any), .elapsed(rfc_el));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_act_bank <= '0;
    else if (act_any) last_act_bank <= bank;
  end

  always_comb begin
    v_rrd = act_any && (bank != last_act_bank) && (rrd_el < RRD_W'(RRD));
    v_ccd = col_any && (ccd_el < CCD_W'(CCD));
    v_mrd = busy_any && (mrd_el < MRD_W'(MRD));
    v_rfc = act_any && (rfc_el < RFC_W'(RFC));
  end
endmodule

// File: rtl/ddr_tmon_top.sv
module ddr_tmon_top
  import ddr_tmon_pkg::*;
#(
  parameter int BANK_W      = 2,
  parameter int CLK_PS      = 7500,
  parameter int TRCD_NS     = 20,
  parameter int TRP_NS      = 20,
  parameter int TRAS_NS     = 45,
  parameter int TRAS_MAX_NS = 120000,
  parameter int TRC_NS      = 65,
  parameter int TRRD_NS     = 15,
  parameter int TRFC_NS     = 75,
  parameter int TWR_CLK     = 2,
  parameter int BURST_CLK   = 2,
  parameter int TCCD_CLK    = 1,
  parameter int TMRD_CLK    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        cmd_op,
  input  logic [BANK_W-1:0] cmd_bank,
  output logic              viol_pulse,
  output logic [NRULE-1:0]  viol_code
);
  timeunit 1ns;
  timeprecision 100ps;

  localparam int NBANK      = 1 << BANK_W;
  localparam int RCD_CLK    = ns_to_clk(TRCD_NS, CLK_PS);
  localparam int RP_CLK     = ns_to_clk(TRP_NS, CLK_PS);
  localparam int RAS_CLK    = ns_to_clk(TRAS_NS, CLK_PS);
  localparam int RASMAX_CLK = max_of(ns_to_clk(TRAS_MAX_NS, CLK_PS), RAS_CLK);
  localparam int RC_CLK     = ns_to_clk(TRC_NS, CLK_PS);
  localparam int RRD_CLK    = ns_to_clk(TRRD_NS, CLK_PS);
  localparam int RFC_CLK    = ns_to_clk(TRFC_NS, CLK_PS);
  localparam int WTP_CLK    = BURST_CLK + TWR_CLK;
  localparam int MRD_CLK    = TMRD_CLK;

  // Decoded command events
  logic             is_act, is_rd, is_wr, is_col, is_pre, is_prea;
  logic             is_ref, is_mrs, is_busy;
  logic [NBANK-1:0] bank_sel;

  assign is_act  = (cmd_op == OP_ACT);
  assign is_rd   = (cmd_op == OP_RD);
  assign is_wr   = (cmd_op == OP_WR);
  assign is_col  = is_rd || is_wr;
  assign is_pre  = (cmd_op == OP_PRE);
  assign is_prea = (cmd_op == OP_PREA);
  assign is_ref  = (cmd_op == OP_REF);
  assign is_mrs  = (cmd_op == OP_MRS);
  assign is_busy = (cmd_op != OP_NOP);

  always_comb begin
    bank_sel = '0;
    bank_sel[cmd_bank] = 1'b1;
  end

  // Per-bank rule hits
  logic [NBANK-1:0] b_rcd, b_rp, b_rasmin, b_rasmax, b_rc, b_wtp;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    ddr_tmon_bank #(
      .RCD(RCD_CLK), .RP(RP_CLK), .RAS(RAS_CLK), .RASMAX(RASMAX_CLK),
      .RC(RC_CLK), .WTP(WTP_CLK)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_hit  (is_act && bank_sel[b]),
      .col_hit  (is_col && bank_sel[b]),
      .wr_hit   (is_wr && bank_sel[b]),
      .pre_hit  ((is_pre && bank_sel[b]) || is_prea),
      .v_rcd    (b_rcd[b]),
      .v_rp     (b_rp[b]),
      .v_rasmin (b_rasmin[b]),
      .v_rasmax (b_rasmax[b]),
      .v_rc     (b_rc[b]),
      .v_wtp    (b_wtp[b])
    );
  end

  logic g_rrd, g_ccd, g_mrd, g_rfc;

  ddr_tmon_global #(
    .BANK_W(BANK_W), .RRD(RRD_CLK), .CCD(TCCD_CLK), .MRD(MRD_CLK), .RFC(RFC_CLK)
  ) u_global (
    .clk      (clk),
    .rst_n    (rst_n),
    .act_any  (is_act),
    .col_any  (is_col),
    .mrs_any  (is_mrs),
    .ref_any  (is_ref),
    .busy_any (is_busy),
    .bank     (cmd_bank),
    .v_rrd    (g_rrd),
    .v_ccd    (g_ccd),
    .v_mrd    (g_mrd),
    .v_rfc    (g_rfc)
  );

  // Named event for the checker: some bank passed its row-open deadline
  logic timeout_evt;
  assign timeout_evt = |b_rasmax;

  logic [NRULE-1:0] raw_code;
  always_comb begin
    raw_code           = '0;
    raw_code[R_RCD]    = |b_rcd;
    raw_code[R_RP]     = |b_rp;
    raw_code[R_RASMIN] = |b_rasmin;
    raw_code[R_RASMAX] = timeout_evt;
    raw_code[R_RC]     = |b_rc;
    raw_code[R_RRD]    = g_rrd;
    raw_code[R_WTP]    = |b_wtp;
    raw_code[R_CCD]    = g_ccd;
    raw_code[R_MRD]    = g_mrd;
    raw_code[R_RFC]    = g_rfc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_code  <= '0;
      viol_pulse <= 1'b0;
    end else begin
      viol_code  <= raw_code;
      viol_pulse <= |{b_rcd, b_rp, b_rasmin, b_rasmax, b_rc, b_wtp,
                      g_rrd, g_ccd, g_mrd, g_rfc};
    end
  end
endmodule

// File: rtl/ddr_tmon_chk.sv
module ddr_tmon_chk
  import ddr_tmon_pkg::*;
#(
  parameter int BANK_W  = 2,
  parameter int RCD_CLK = 3,
  parameter int RRD_CLK = 2,
  parameter int MRD_CLK = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2:0]        cmd_op,
  input logic [BANK_W-1:0] cmd_bank,
  input logic              timeout_evt,
  input logic              viol_pulse,
  input logic [NRULE-1:0]  viol_code
);
  timeunit 1ns;
  timeprecision 100ps;

  // R13: pulse agrees with the code it accompanies
  p_pulse_matches_code_r13: assert property (@(posedge clk) disable iff (!rst_n)
    viol_pulse == (viol_code != '0));

  // R13: a no-op cycle with no row deadline reports nothing
  p_nop_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == OP_NOP && !timeout_evt) |=> (viol_code == '0));

  // R4: a row deadline event is reported in the next cycle
  p_timeout_reported_r4: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_evt |=> viol_code[R_RASMAX]);

  if (RCD_CLK >= 2) begin : g_rcd
    // R1: column command right after activate of the same bank
    p_rcd_back_to_back_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_op == OP_RD || cmd_op == OP_WR) && $past(cmd_op) == OP_ACT &&
       $past(cmd_bank) == cmd_bank) |=> viol_code[R_RCD]);
  end

  if (RRD_CLK >= 2) begin : g_rrd
    // R6: activates to different banks on consecutive cycles
    p_rrd_back_to_back_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_ACT && $past(cmd_op) == OP_ACT &&
       $past(cmd_bank) != cmd_bank) |=> viol_code[R_RRD]);
  end

  if (MRD_CLK >= 2) begin : g_mrd
    // R9: any command right after a mode-register set
    p_mrd_back_to_back_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(cmd_op) == OP_MRS && cmd_op != OP_NOP) |=> viol_code[R_MRD]);
  end
endmodule

bind ddr_tmon_top ddr_tmon_chk #(
  .BANK_W(BANK_W), .RCD_CLK(RCD_CLK), .RRD_CLK(RRD_CLK), .MRD_CLK(MRD_CLK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cmd_op      (cmd_op),
  .cmd_bank    (cmd_bank),
  .timeout_evt (timeout_evt),
  .viol_pulse  (viol_pulse),
  .viol_code   (viol_code)
);

// File: tb/tb_ddr_tmon_top.sv
module tb_ddr_tmon_top;
  import ddr_tmon_pkg::*;
  timeunit 1ns;
  timeprecision 100ps;

  // Bench limits: 7.5 ns notional period -> RCD 3, RP 3, RAS 6, RAS max 80,
  // RC 9, RRD 2, RFC 10; write-to-precharge 4, CCD 2, MRD 2.
  localparam logic [NRULE-1:0] M_RCD    = NRULE'(1) << R_RCD;
  localparam logic [NRULE-1:0] M_RP     = NRULE'(1) << R_RP;
  localparam logic [NRULE-1:0] M_RASMIN = NRULE'(1) << R_RASMIN;
  localparam logic [NRULE-1:0] M_RASMAX = NRULE'(1) << R_RASMAX;
  localparam logic [NRULE-1:0] M_RC     = NRULE'(1) << R_RC;
  localparam logic [NRULE-1:0] M_RRD    = NRULE'(1) << R_RRD;
  localparam logic [NRULE-1:0] M_WTP    = NRULE'(1) << R_WTP;
  localparam logic [NRULE-1:0] M_CCD    = NRULE'(1) << R_CCD;
  localparam logic [NRULE-1:0] M_MRD    = NRULE'(1) << R_MRD;
  localparam logic [NRULE-1:0] M_RFC    = NRULE'(1) << R_RFC;
  localparam logic [NRULE-1:0] M_NONE   = '0;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [2:0]       cmd_op = OP_NOP;
  logic [1:0]       cmd_bank = 2'd0;
  logic             viol_pulse;
  logic [NRULE-1:0] viol_code;
  int               n_chk = 0;
  int               n_fail = 0;
  bit               done = 1'b0;

  always #2 clk = ~clk;

  ddr_tmon_top #(.TRAS_MAX_NS(600), .TCCD_CLK(2)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
    .viol_pulse(viol_pulse), .viol_code(viol_code));

  task automatic check(input string tag, input logic [NRULE-1:0] exp);
    n_chk++;
    if (viol_code !== exp || viol_pulse !== (exp != '0)) begin
      n_fail++;
      $display("FAIL %s: code=%h pulse=%b expected code=%h pulse=%b",
               tag, viol_code, viol_pulse, exp, (exp != '0));
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge
  task automatic cyc(input op_e op, input int bank, input logic [NRULE-1:0] exp,
                     input string tag);
    cmd_op   = op;
    cmd_bank = 2'(bank);
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic nops(input int n, input string tag);
    for (int i = 0; i < n; i++) cyc(OP_NOP, 0, M_NONE, tag);
  endtask

  task automatic close_all(input string tag);
    nops(8, tag);
    cyc(OP_PREA, 0, M_NONE, tag);
    nops(12, tag);
  endtask

  task automatic t_reset;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R14 in reset", M_NONE);
    end
    rst_n = 1'b1;
    cyc(OP_ACT, 0, M_NONE, "R14 activate right after reset");
    close_all("R14 close");
  endtask

  task automatic t_rcd_ccd;
    cyc(OP_ACT, 0, M_NONE, "R1 act");
    nops(1, "R1 gap");
    cyc(OP_RD, 0, M_RCD, "R1 read 2 cycles after act");
    nops(1, "R1 gap");
    cyc(OP_WR, 0, M_NONE, "R1 R8 write on limits");
    cyc(OP_RD, 0, M_CCD, "R8 read 1 cycle after write");
    nops(1, "R8 gap");
    cyc(OP_RD, 0, M_NONE, "R8 read on limit");
    close_all("R1 close");
  endtask

  task automatic t_combined;
    cyc(OP_ACT, 1, M_NONE, "R13 act");
    cyc(OP_RD, 1, M_RCD, "R13 read after 1");
    cyc(OP_RD, 1, M_RCD | M_CCD, "R13 two bits together");
    close_all("R13 close");
  endtask

  task automatic t_row_rules;
    cyc(OP_ACT, 2, M_NONE, "R3 act");
    nops(4, "R3 gap");
    cyc(OP_PRE, 2, M_RASMIN, "R3 precharge at 5");
    nops(1, "R2 gap");
    cyc(OP_ACT, 2, M_RP | M_RC, "R2 R5 act too soon");
    nops(5, "R3 gap");
    cyc(OP_PRE, 2, M_NONE, "R3 precharge on limit");
    nops(2, "R2 gap");
    cyc(OP_ACT, 2, M_NONE, "R2 R5 act on limits");
    close_all("R5 close");
  endtask

  task automatic t_rrd;
    cyc(OP_ACT, 0, M_NONE, "R6 act b0");
    cyc(OP_ACT, 1, M_RRD, "R6 act b1 after 1");
    nops(1, "R6 gap");
    cyc(OP_ACT, 2, M_NONE, "R6 act b2 on limit");
    cyc(OP_ACT, 3, M_RRD, "R6 act b3 after 1");
    close_all("R6 close");
  endtask

  task automatic t_write_recovery;
    cyc(OP_ACT, 3, M_NONE, "R7 act");
    nops(2, "R7 gap");
    cyc(OP_WR, 3, M_NONE, "R7 write");
    nops(2, "R7 gap");
    cyc(OP_PRE, 3, M_WTP, "R7 precharge 3 after write");
    nops(2, "R7 gap");
    cyc(OP_ACT, 3, M_NONE, "R7 reopen");
    nops(2, "R7 gap");
    cyc(OP_WR, 3, M_NONE, "R7 write again");
    nops(3, "R7 gap");
    cyc(OP_PRE, 3, M_NONE, "R7 precharge 4 after write");
    nops(12, "R7 idle");
  endtask

  task automatic t_mrd;
    cyc(OP_MRS, 0, M_NONE, "R9 mrs");
    cyc(OP_PRE, 2, M_MRD, "R9 command 1 after mrs");
    cyc(OP_MRS, 0, M_NONE, "R9 mrs again");
    nops(1, "R9 gap");
    cyc(OP_ACT, 0, M_NONE, "R9 act on limit");
    close_all("R9 close");
  endtask

  task automatic t_rfc;
    cyc(OP_REF, 0, M_NONE, "R10 refresh");
    nops(4, "R10 gap");
    cyc(OP_ACT, 1, M_RFC, "R10 act 5 after refresh");
    nops(4, "R10 gap");
    cyc(OP_ACT, 2, M_NONE, "R10 act 10 after refresh");
    close_all("R10 close");
  endtask

  task automatic t_prea;
    cyc(OP_ACT, 0, M_NONE, "R11 act b0");
    nops(1, "R11 gap");
    cyc(OP_ACT, 1, M_NONE, "R11 act b1");
    nops(3, "R11 gap");
    cyc(OP_PREA, 0, M_RASMIN, "R11 precharge-all with b1 young");
    nops(1, "R11 gap");
    cyc(OP_ACT, 0, M_RP | M_RC, "R11 b0 closed by precharge-all");
    close_all("R11 close");
  endtask

  task automatic t_idle_pre;
    cyc(OP_PRE, 2, M_NONE, "R12 precharge idle bank");
    cyc(OP_ACT, 2, M_NONE, "R12 act right after");
    close_all("R12 close");
  endtask

  task automatic t_row_max;
    cyc(OP_ACT, 0, M_NONE, "R4 act");
    nops(79, "R4 before deadline");
    cyc(OP_NOP, 0, M_RASMAX, "R4 deadline reached");
    nops(150, "R4 R14 no repeat or wrap");
    cyc(OP_PRE, 0, M_NONE, "R4 late precharge");
    nops(12, "R4 idle");
    cyc(OP_ACT, 1, M_NONE, "R4 act b1");
    nops(79, "R4 before deadline b1");
    cyc(OP_PRE, 1, M_NONE, "R4 precharge on deadline");
    nops(12, "R4 no late report");
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    t_reset();
    t_rcd_ccd();
    t_combined();
    t_row_rules();
    t_rrd();
    t_write_recovery();
    t_mrd();
    t_rfc();
    t_prea();
    t_idle_pre();
    t_row_max();
    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not end, expected completion");
      summary();
      $finish;
    end
  end
endmodule